// File: doc/BRIEF.md
# MOVX Auxiliary RAM Router

This block sits between an 8051-style core and its external data space. Each MOVX-type access is presented with either an 8-bit pointer taken from R0 or R1 of the active register bank, or the 16-bit data pointer. The block sends the access to one of two places: a 256-byte on-chip auxiliary RAM, or an external bus request port.

The auxiliary RAM is switched off after reset. While it is off, every access goes out to the external bus, including addresses below 256. Software turns the window on by setting bit 4 of a chip-control register. From then on, accesses at addresses 0000h to 00FFh are served on chip in one cycle. Anything higher still goes out to the external bus.

An external access raises a request that carries the 16-bit address, the direction and the write data. The request stays up until the bus side acknowledges it. The timing of the bus cycle itself is handled elsewhere.

Top module: `xram_router`

## Requirements
- R1: While reset is asserted and directly after it, the control register reads 00h, `ext_req` is low and `acc_done` is low.
- R2: When control bit 4 is 0, every accepted access raises `ext_req`, whatever its address. The request carries the access address and direction, and the data when it is a write.
- R3: When `acc_use_dptr` is 0, the 8-bit pointer is zero-extended, so the upper byte of the resolved address is 00h.
- R4: When control bit 4 is 1, an accepted access whose resolved address is below 0100h completes on chip. `acc_done` pulses in the cycle after acceptance and `ext_req` stays low.
- R5: An accepted access whose resolved address is 0100h or above always raises `ext_req` with that address, even when control bit 4 is 1.
- R6: `ext_req`, `ext_addr`, `ext_write` and `ext_wdata` hold steady until `ext_ack` is seen high. The request then drops, and in the following cycle `acc_done` pulses. For a read, `acc_rdata` carries the `ext_rdata` value sampled with the acknowledge.
- R7: An on-chip read returns the byte last written on chip at that address. Clearing and then setting control bit 4 does not lose the contents. For a write, `acc_rdata` returns the data written.
- R8: The control register reads back the full byte last written. Only bit 4 affects routing.
- R9: An access is accepted only while `ext_req` is low. An `acc_valid` seen while a request is pending has no effect on the pending request or on the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the chip-control register |
| ctrl_wdata | input | 8 | Chip-control write data; bit 4 enables the window |
| ctrl_rdata | output | 8 | Chip-control register contents |
| acc_valid | input | 1 | Access request from the core |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_use_dptr | input | 1 | 1 = use the 16-bit data pointer, 0 = use the 8-bit pointer |
| acc_ptr | input | 8 | R0/R1 pointer value |
| acc_dptr | input | 16 | Data pointer value |
| acc_wdata | input | 8 | Write data |
| acc_done | output | 1 | One-cycle completion pulse |
| acc_rdata | output | 8 | Read data, valid with `acc_done` |
| ext_req | output | 1 | External access request; also marks the block as busy |
| ext_write | output | 1 | Direction of the external access |
| ext_addr | output | 16 | External access address |
| ext_wdata | output | 8 | External write data |
| ext_ack | input | 1 | External access acknowledge |
| ext_rdata | input | 8 | External read data, sampled with `ext_ack` |

## Verification
The properties assume three things about the bus side. `ext_ack` is raised only while `ext_req` is high. Read data is valid in the cycle the acknowledge is seen. The pointer and direction inputs are steady in the cycle that `acc_valid` is sampled.

The bench's bus responder asserts `ext_ack` only against a live request, for exactly one cycle and after a chosen latency. The core-side driver changes inputs only just after a clock edge. Accesses made while the block is busy are still driven on purpose, to show they are ignored.

// File: rtl/xram_router.sv
module xram_router #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int WIN_AW = 8,
  parameter int EN_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] ctrl_wdata,
  output logic [DATA_W-1:0] ctrl_rdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_use_dptr,
  input  logic [WIN_AW-1:0] acc_ptr,
  input  logic [ADDR_W-1:0] acc_dptr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              acc_done,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              ext_req,
  output logic              ext_write,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic              ext_ack,
  input  logic [DATA_W-1:0] ext_rdata
);
  localparam int WIN_DEPTH = 1 << WIN_AW;
  localparam int HI_W      = ADDR_W - WIN_AW;

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] win_mem [WIN_DEPTH];
  logic              req_q, wr_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q, rd_q;

  logic [ADDR_W-1:0] acc_addr;
  logic              take, go_int, in_win;

  assign acc_addr = acc_use_dptr ? acc_dptr : {{HI_W{1'b0}}, acc_ptr};
  assign in_win   = ~|acc_addr[ADDR_W-1:WIN_AW];
  assign take     = acc_valid & ~req_q;
  assign go_int   = take & ctrl_q[EN_BIT] & in_win;

  assign ctrl_rdata = ctrl_q;
  assign acc_done   = done_q;
  assign acc_rdata  = rd_q;
  assign ext_req    = req_q;
  assign ext_write  = wr_q;
  assign ext_addr   = addr_q;
  assign ext_wdata  = wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_wdata;
  end

  always_ff @(posedge clk) begin
    if (go_int && acc_write) win_mem[acc_addr[WIN_AW-1:0]] <= acc_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else if (req_q) begin
      done_q <= ext_ack;
      if (ext_ack) begin
        req_q <= 1'b0;
        rd_q  <= wr_q ? wd_q : ext_rdata;
      end
    end else if (go_int) begin
      done_q <= 1'b1;
      rd_q   <= acc_write ? acc_wdata : win_mem[acc_addr[WIN_AW-1:0]];
    end else if (take) begin
      done_q <= 1'b0;
      req_q  <= 1'b1;
      wr_q   <= acc_write;
      addr_q <= acc_addr;
      wd_q   <= acc_wdata;
    end else begin
      done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/xram_router_chk.sv
module xram_router_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int WIN_AW = 8,
  parameter int EN_BIT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] ctrl_rdata,
  input logic              acc_valid,
  input logic              acc_write,
  input logic              acc_use_dptr,
  input logic [WIN_AW-1:0] acc_ptr,
  input logic [ADDR_W-1:0] acc_dptr,
  input logic              acc_done,
  input logic              ext_req,
  input logic              ext_write,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              ext_ack
);
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!ext_req && !acc_done && ctrl_rdata == '0));

  p_off_goes_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !ext_req && !ctrl_rdata[EN_BIT] |=> ext_req && ext_write == $past(acc_write));

  p_ptr_zero_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !ext_req && !acc_use_dptr && !ctrl_rdata[EN_BIT]
    |=> ext_addr == {{(ADDR_W-WIN_AW){1'b0}}, $past(acc_ptr)});

  p_window_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !ext_req && ctrl_rdata[EN_BIT] && (!acc_use_dptr || acc_dptr[ADDR_W-1:WIN_AW] == '0)
    |=> acc_done && !ext_req);

  p_high_addr_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !ext_req && acc_use_dptr && acc_dptr[ADDR_W-1:WIN_AW] != '0
    |=> ext_req && ext_addr == $past(acc_dptr));

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !ext_ack |=> ext_req && $stable(ext_addr) && $stable(ext_write));

  p_ack_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && ext_ack |=> acc_done && !ext_req);

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !ext_ack && acc_valid |=> ext_req && !acc_done);
endmodule

bind xram_router xram_router_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .EN_BIT(EN_BIT)
) chk_i (.*);

// File: tb/xram_router_tb_top.sv
module xram_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic [7:0]  ctrl_rdata;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_use_dptr = 1'b0;
  logic [7:0]  acc_ptr = '0;
  logic [15:0] acc_dptr = '0;
  logic [7:0]  acc_wdata = '0;
  logic        acc_done;
  logic [7:0]  acc_rdata;
  logic        ext_req, ext_write;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic        ext_ack = 1'b0;
  logic [7:0]  ext_rdata = '0;

  int checks = 0, errors = 0;
  int lat = 1, wait_cnt = 0;

  always #2 clk = ~clk;

  xram_router dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bus_data(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // bus responder: one-cycle ack after lat cycles of a live request
  always @(posedge clk) begin
    #1;
    if (ext_req) begin
      wait_cnt++;
      ext_ack   = (wait_cnt == lat);
      ext_rdata = bus_data(ext_addr);
    end else begin
      wait_cnt = 0;
      ext_ack  = 1'b0;
    end
  end

  // behavioural reference
  logic [7:0]  m_mem [256];
  logic [7:0]  m_ctrl = '0, m_rd = '0, m_wd = '0;
  logic        m_req = 1'b0, m_wr = 1'b0, m_done = 1'b0;
  logic [15:0] m_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_req = 1'b0; m_done = 1'b0; m_rd = '0;
    end else begin
      logic [15:0] a;
      a = acc_use_dptr ? acc_dptr : {8'h00, acc_ptr};
      m_done = 1'b0;
      if (m_req) begin
        if (ext_ack) begin
          m_req = 1'b0; m_done = 1'b1;
          m_rd = m_wr ? m_wd : ext_rdata;
        end
      end else if (acc_valid) begin
        if (m_ctrl[4] && a < 16'h0100) begin
          if (acc_write) m_mem[a[7:0]] = acc_wdata;
          m_rd = m_mem[a[7:0]];
          m_done = 1'b1;
        end else begin
          m_req = 1'b1; m_wr = acc_write; m_addr = a; m_wd = acc_wdata;
        end
      end
      if (ctrl_we) m_ctrl = ctrl_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 ctrl", ctrl_rdata, m_ctrl);
      chk("R4 ext_req", ext_req, m_req);
      chk("R6 done", acc_done, m_done);
      if (m_req) begin
        chk("R5 ext_addr", ext_addr, m_addr);
        chk("R2 ext_write", ext_write, m_wr);
        if (m_wr) chk("R2 ext_wdata", ext_wdata, m_wd);
      end
      if (m_done) chk("R7 rdata", acc_rdata, m_rd);
    end
  end

  logic        went_ext;
  logic [15:0] seen_addr;
  logic [7:0]  got;

  task automatic ctrl_write(input logic [7:0] v);
    @(posedge clk); #1; ctrl_we = 1'b1; ctrl_wdata = v;
    @(posedge clk); #1; ctrl_we = 1'b0;
  endtask

  task automatic access(input logic wr, input logic use_d, input logic [7:0] p,
                        input logic [15:0] d, input logic [7:0] wd);
    @(posedge clk); #1;
    acc_valid = 1'b1; acc_write = wr; acc_use_dptr = use_d;
    acc_ptr = p; acc_dptr = d; acc_wdata = wd;
    @(posedge clk); #1; acc_valid = 1'b0;
    @(negedge clk);
    went_ext = ext_req; seen_addr = ext_addr;
    while (!acc_done) @(negedge clk);
    got = acc_rdata;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ctrl", ctrl_rdata, 0);
    chk("R1 ext_req", ext_req, 0);
    chk("R1 done", acc_done, 0);
    @(posedge clk); #1; rst_n = 1'b1;

    access(1'b0, 1'b0, 8'h12, 16'h0, 8'h0);
    chk("R2 low read goes out while off", went_ext, 1);
    chk("R3 zero-extended pointer", seen_addr, 16'h0012);
    chk("R6 read data from bus", got, bus_data(16'h0012));
    access(1'b1, 1'b1, 8'h0, 16'h0040, 8'h77);
    chk("R2 low write goes out while off", went_ext, 1);

    ctrl_write(8'h10);
    chk("R8 readback", ctrl_rdata, 8'h10);
    access(1'b1, 1'b0, 8'h33, 16'h0, 8'hA5);
    chk("R4 pointer write on chip", went_ext, 0);
    access(1'b1, 1'b1, 8'h0, 16'h00C0, 8'h3C);
    chk("R4 dptr write on chip", went_ext, 0);
    access(1'b0, 1'b0, 8'h33, 16'h0, 8'h0);
    chk("R7 read back 33", got, 8'hA5);
    access(1'b0, 1'b1, 8'h0, 16'h00C0, 8'h0);
    chk("R7 read back C0", got, 8'h3C);
    chk("R4 read on chip", went_ext, 0);

    access(1'b0, 1'b1, 8'h0, 16'h0100, 8'h0);
    chk("R5 0100 goes out", went_ext, 1);
    chk("R5 address", seen_addr, 16'h0100);
    access(1'b1, 1'b1, 8'h0, 16'hFFFF, 8'h99);
    chk("R5 FFFF goes out", seen_addr, 16'hFFFF);

    lat = 4;
    @(posedge clk); #1;
    acc_valid = 1'b1; acc_write = 1'b0; acc_use_dptr = 1'b1; acc_dptr = 16'h2345;
    @(posedge clk); #1;
    acc_dptr = 16'h0033; acc_write = 1'b1; acc_wdata = 8'h00;
    @(posedge clk); #1;
    acc_valid = 1'b0;
    while (!acc_done) @(negedge clk);
    chk("R9 pending read data", acc_rdata, bus_data(16'h2345));
    access(1'b0, 1'b0, 8'h33, 16'h0, 8'h0);
    chk("R9 busy write dropped", got, 8'hA5);
    lat = 1;

    ctrl_write(8'hEF);
    access(1'b0, 1'b0, 8'h33, 16'h0, 8'h0);
    chk("R8 other bits do not enable", went_ext, 1);
    ctrl_write(8'h10);
    access(1'b0, 1'b0, 8'h33, 16'h0, 8'h0);
    chk("R7 kept across disable", got, 8'hA5);

    begin
      int seed = 7;
      for (int i = 0; i < 60; i++) begin
        logic [15:0] d;
        seed = seed * 1103515245 + 12345;
        lat = 1 + ((seed >>> 8) & 3);
        d = ((seed >>> 4) & 1) ? 16'h0100 + 16'((seed >>> 12) & 16'hFF) : 16'h00C0;
        if (((seed >>> 20) & 7) == 0) ctrl_write(8'((seed >>> 16) & 8'hFF) | 8'h10);
        access(1'((seed >>> 2) & 1), 1'b1, 8'h0, d, 8'((seed >>> 24) & 8'hFF));
      end
    end

    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule